// File: doc/BRIEF.md
# LCD Common-Phase Sequencer with Frame Interrupt

This block steps a multiplexed LCD driver through its common (COM) phases. One phase lasts from one `phase_tick` to the next, and a frame is one full pass over the active phases. Each time the sequence wraps back to COM0, the block pulses `frame_start`, because a new frame begins when COM0 becomes active.

For Type-B waveforms with multiplexed drive, the pixel pattern must stay the same across an even/odd pair of frames. Otherwise the odd frame is not the complement of the even frame, and the panel sees a DC offset. To support this, the block tracks frame parity. Once per pair, when the odd frame enters its final phase, it raises a sticky interrupt flag. At that point all pixel data for the frame has been fetched, and the next frame boundary is a fixed time away. The same event opens a write window of fixed length. A pixel write strobe that arrives while the window is closed sets a sticky error flag. Type-A waveforms and static drive produce neither an interrupt nor a window.

Top module: `lcd_frame_irq`

## Requirements
- R1: The active COM index starts at 0. It advances by one on each cycle with `phase_tick` high, and it returns to 0 on the tick after index `mux_sel`. With `mux_sel` = 0 it stays at 0.
- R2: `frame_start` is high for exactly one cycle: the first cycle in which `com_idx` is 0 after a wrap. It is low at all other times, including while `mux_sel` = 0 and no tick occurs.
- R3: With `wave_sel` = 1 (Type-B) and `mux_sel` != 0, the frame parity is even after reset and toggles at every wrap. The interrupt event is the tick that moves `com_idx` from `mux_sel`-1 to `mux_sel` during an odd frame. This gives one event per two frames.
- R4: With `wave_sel` = 0 (Type-A), or with `mux_sel` = 0, no interrupt is raised and `wr_en` stays low.
- R5: `irq_flag` goes high in the cycle after the event tick, which is the same cycle in which `com_idx` first shows `mux_sel`. It stays high until a cycle with `flag_clr` high. If an event and `flag_clr` occur in the same cycle, the flag is set.
- R6: `wr_en` goes high in the same cycle as the interrupt. It stays high for exactly WIN_UNIT*(`mux_sel`+1)+WIN_EXTRA cycles (33 for `mux_sel`=3 with the default values 8 and 1). A new event restarts this count.
- R7: A cycle with `pix_wr` high while `wr_en` is low sets `wr_err` in the next cycle. A `pix_wr` while `wr_en` is high leaves `wr_err` unchanged.
- R8: `wr_err` stays high until a cycle with `flag_clr` high. If an error and `flag_clr` occur in the same cycle, the flag is set.
- R9: While `rst_n` is low, `com_idx` is 0 and `frame_start`, `irq_flag`, `wr_en` and `wr_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_tick | input | 1 | One-cycle strobe that ends the current COM phase |
| mux_sel | input | 2 | Number of COM phases minus one (0 = static) |
| wave_sel | input | 1 | Waveform type: 0 = Type-A, 1 = Type-B |
| pix_wr | input | 1 | Pixel memory write strobe |
| flag_clr | input | 1 | Clears `irq_flag` and `wr_err` |
| com_idx | output | 2 | Index of the active COM phase |
| frame_start | output | 1 | One-cycle pulse on entry into COM0 |
| irq_flag | output | 1 | Sticky frame interrupt flag |
| wr_en | output | 1 | Pixel write window open |
| wr_err | output | 1 | Sticky flag for a write outside the window |

## Verification
The assertions assume that `mux_sel` and `wave_sel` change only while reset is held. Without this, the phase index could end up beyond the last phase, and parity would lose track of the frame pair. The stimulus follows this rule: it applies every mode under reset and then keeps the mode fixed. It spaces ticks at least five cycles apart, so that a whole frame pair is longer than the write window. The clear strobe is sometimes held high across interrupt events, which exercises the case where set and clear arrive in the same cycle.

// File: rtl/lcd_fi_pkg.sv
package lcd_fi_pkg;
    typedef logic [1:0] com_t;

    typedef enum logic {
        WAVE_A = 1'b0,
        WAVE_B = 1'b1
    } wave_e;

    typedef struct packed {
        com_t com;
        logic par;
        logic fs;
    } seq_state_t;
endpackage

// File: rtl/lcd_fi_seq.sv
module lcd_fi_seq
    import lcd_fi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_tick,
    input  logic [1:0] mux_sel,
    input  logic       wave_b,
    output com_t       com_idx,
    output logic       frame_start,
    output logic       irq_evt
);
    seq_state_t st_d, st_q;
    logic       wrap;
    com_t       pre_last;

    always_comb begin
        st_d     = st_q;
        st_d.fs  = 1'b0;
        pre_last = mux_sel - 2'd1;
        wrap     = phase_tick && (st_q.com >= mux_sel);
        irq_evt  = phase_tick && wave_b && (mux_sel != 2'd0)
                   && (st_q.com == pre_last) && st_q.par;
        if (phase_tick) begin
            if (wrap) begin
                st_d.com = '0;
                st_d.fs  = 1'b1;
                if (wave_b) st_d.par = ~st_q.par;
            end else begin
                st_d.com = st_q.com + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_idx     = st_q.com;
    assign frame_start = st_q.fs;

    // R2
    fs_at_com0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (com_idx == 2'd0));

    // R1
    static_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel == 2'd0) |=> (com_idx == 2'd0));
endmodule

// File: rtl/lcd_fi_flag.sv
module lcd_fi_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q = flag_q;

    // R5 R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    // R5 R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
endmodule

// File: rtl/lcd_fi_window.sv
module lcd_fi_window #(
    parameter int WIN_UNIT  = 8,
    parameter int WIN_EXTRA = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open_evt,
    input  logic       mode_ok,
    input  logic [1:0] mux_sel,
    output logic       wr_en
);
    localparam int MAX_LEN = WIN_UNIT * 4 + WIN_EXTRA;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t w_d, w_q;
    logic [CNT_W-1:0] win_len;

    always_comb begin
        win_len = CNT_W'(WIN_UNIT * (int'(mux_sel) + 1) + WIN_EXTRA);
        w_d     = w_q;
        if (!mode_ok) begin
            w_d = '0;
        end else if (open_evt) begin
            w_d.on  = 1'b1;
            w_d.cnt = win_len - 1'b1;
        end else if (w_q.cnt != '0) begin
            w_d.cnt = w_q.cnt - 1'b1;
        end else begin
            w_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wr_en = w_q.on;

    // R4
    no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> !wr_en);

    // R6
    window_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_evt && mode_ok) |=> wr_en);
endmodule

// File: rtl/lcd_frame_irq.sv
module lcd_frame_irq
    import lcd_fi_pkg::*;
#(
    parameter int WIN_UNIT  = 8,
    parameter int WIN_EXTRA = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_tick,
    input  logic [1:0] mux_sel,
    input  logic       wave_sel,
    input  logic       pix_wr,
    input  logic       flag_clr,
    output logic [1:0] com_idx,
    output logic       frame_start,
    output logic       irq_flag,
    output logic       wr_en,
    output logic       wr_err
);
    logic wave_b, mode_ok, irq_evt, err_evt;

    assign wave_b  = (wave_e'(wave_sel) == WAVE_B);
    assign mode_ok = wave_b && (mux_sel != 2'd0);
    assign err_evt = pix_wr && !wr_en;

    lcd_fi_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_tick  (phase_tick),
        .mux_sel     (mux_sel),
        .wave_b      (wave_b),
        .com_idx     (com_idx),
        .frame_start (frame_start),
        .irq_evt     (irq_evt)
    );

    lcd_fi_window #(
        .WIN_UNIT  (WIN_UNIT),
        .WIN_EXTRA (WIN_EXTRA)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_evt (irq_evt),
        .mode_ok  (mode_ok),
        .mux_sel  (mux_sel),
        .wr_en    (wr_en)
    );

    lcd_fi_flag u_irq_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_evt),
        .clr   (flag_clr),
        .q     (irq_flag)
    );

    lcd_fi_flag u_err_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_evt),
        .clr   (flag_clr),
        .q     (wr_err)
    );

    // R6
    window_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> irq_flag);

    // R5
    irq_at_last_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |=> (com_idx == mux_sel));

    // R7
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_wr && !wr_en) |=> wr_err);
endmodule

// File: tb/test_lcd_frame_irq.sv
module test_lcd_frame_irq;
    localparam int WU = 8;
    localparam int WE = 1;

    typedef struct {
        logic [1:0] com;
        logic       fs;
        logic       irq;
        logic       wen;
        logic       err;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_tick = 1'b0;
    logic [1:0] mux_sel = 2'd0;
    logic       wave_sel = 1'b0;
    logic       pix_wr = 1'b0;
    logic       flag_clr = 1'b0;
    logic [1:0] com_idx;
    logic       frame_start, irq_flag, wr_en, wr_err;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t exp_q[$];

    logic [1:0] m_com;
    logic       m_par, m_fs, m_irq, m_wen, m_err;
    int         m_cnt;

    always #2 clk = ~clk;

    lcd_frame_irq #(.WIN_UNIT(WU), .WIN_EXTRA(WE)) i_lcd_frame_irq (
        .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .mux_sel(mux_sel),
        .wave_sel(wave_sel), .pix_wr(pix_wr), .flag_clr(flag_clr),
        .com_idx(com_idx), .frame_start(frame_start), .irq_flag(irq_flag),
        .wr_en(wr_en), .wr_err(wr_err)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare each output cycle against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check("R1 com_idx", int'(com_idx), int'(e.com));
                check("R2 frame_start", int'(frame_start), int'(e.fs));
                check("R5 irq_flag (R3/R4)", int'(irq_flag), int'(e.irq));
                check("R6 wr_en (R4)", int'(wr_en), int'(e.wen));
                check("R7/R8 wr_err", int'(wr_err), int'(e.err));
            end
        end
    end

    // Driver: apply inputs for one cycle and push the expected next outputs
    task automatic step(logic tk, logic wr, logic clr);
        logic ok, evt, wrap;
        exp_t e;
        @(negedge clk);
        phase_tick = tk;
        pix_wr     = wr;
        flag_clr   = clr;
        ok   = wave_sel && (mux_sel != 2'd0);
        evt  = tk && ok && (m_com == mux_sel - 2'd1) && m_par;
        wrap = tk && (m_com >= mux_sel);
        if (wr && !m_wen) m_err = 1'b1;
        else if (clr)     m_err = 1'b0;
        if (evt)          m_irq = 1'b1;
        else if (clr)     m_irq = 1'b0;
        if (!ok) begin
            m_wen = 1'b0; m_cnt = 0;
        end else if (evt) begin
            m_wen = 1'b1; m_cnt = WU * (int'(mux_sel) + 1) + WE - 1;
        end else if (m_cnt != 0) begin
            m_cnt--;
        end else begin
            m_wen = 1'b0;
        end
        m_fs = wrap;
        if (tk) begin
            if (wrap) begin
                m_com = 2'd0;
                if (wave_sel) m_par = ~m_par;
            end else begin
                m_com = m_com + 2'd1;
            end
        end
        e.com = m_com; e.fs = m_fs; e.irq = m_irq; e.wen = m_wen; e.err = m_err;
        exp_q.push_back(e);
    endtask

    task automatic restart(logic [1:0] mux, logic wb);
        @(negedge clk);
        rst_n = 1'b0; phase_tick = 1'b0; pix_wr = 1'b0; flag_clr = 1'b0;
        mux_sel = mux; wave_sel = wb;
        m_com = 2'd0; m_par = 1'b0; m_fs = 1'b0; m_irq = 1'b0;
        m_wen = 1'b0; m_err = 1'b0; m_cnt = 0;
        repeat (3) @(negedge clk);
        // R9: outputs at their reset values while reset is held
        check("R9 com_idx", int'(com_idx), 0);
        check("R9 frame_start", int'(frame_start), 0);
        check("R9 irq_flag", int'(irq_flag), 0);
        check("R9 wr_en", int'(wr_en), 0);
        check("R9 wr_err", int'(wr_err), 0);
        rst_n = 1'b1;
    endtask

    task automatic run(int n, int tick_gap, int wr_mod, int clr_mod, bit clr_hold);
        for (int i = 0; i < n; i++) begin
            logic tk, wr, clr;
            tk  = ((i % tick_gap) == tick_gap - 1);
            wr  = (wr_mod != 0) && ((i % wr_mod) == 3);
            clr = clr_hold || ((clr_mod != 0) && ((i % clr_mod) == clr_mod - 2));
            step(tk, wr, clr);
        end
    endtask

    initial begin
        // R3 R5 R6 R7 R8: quarter duty Type-B
        restart(2'd3, 1'b1);
        run(320, 5, 7, 23, 1'b0);
        // R3 R6: half duty with long pair gaps and sparse writes
        restart(2'd1, 1'b1);
        run(200, 6, 11, 37, 1'b0);
        // R5 R8: clear held while events and errors occur (set wins)
        restart(2'd2, 1'b1);
        run(200, 6, 5, 0, 1'b1);
        // R6: no clears, windows restart on each pair
        restart(2'd2, 1'b1);
        run(200, 7, 0, 0, 1'b0);
        // R4: Type-A never raises interrupt or window
        restart(2'd3, 1'b0);
        run(120, 5, 4, 41, 1'b0);
        // R1 R2 R4: static Type-B
        restart(2'd0, 1'b1);
        run(80, 5, 6, 29, 1'b0);
        // R1 R2: static with back-to-back ticks
        restart(2'd0, 1'b0);
        run(20, 1, 0, 0, 1'b0);
        @(negedge clk);
        phase_tick = 1'b0; pix_wr = 1'b0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired: actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule